// File: doc/BRIEF.md
# Compare-Period Up-Counting Timer

This block is a single programmable periodic timer. A compare register sets the period, and a 16-bit mode register enables or stops counting. When counting is turned on with a non-zero compare value, the compare value is copied into a private period register and the counter starts from zero. The counter then advances by one every clock. When it completes a full period, the block raises a one-cycle interrupt and the count starts again from zero.

Software reaches the block through a small register port. The mode register can be written one byte at a time or as a halfword. Writes to the mode register that break its rules are rejected, and the block then raises a one-cycle error flag. Writes to the compare register do not change the running period; the new value takes effect the next time counting is enabled. A stopped timer always reads a count of zero.

Address map (byte address `bus_addr`):
- 0: low mode byte. Also the halfword mode word, with bits 7:0 as the low byte and bits 15:8 as the high byte.
- 1: high mode byte, taken from `bus_wdata[7:0]`.
- 2: compare register.
- 4: running count (read only).

Reading address 0 returns the full mode word, and reading address 1 returns the high byte. The transfer size `bus_size` is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = wider.

Top module: `cmpt_timer`

## Requirements
- R1: After reset, the mode word reads 0x0000, the count reads 0, and `irq_o` and `err_o` are low.
- R2: While the timer is stopped, the count reads 0, and changes to the compare register do not start it.
- R3: A legal write that reaches the high mode byte with the enable bit (high byte bit 7, mode word bit 15) set, while the compare value is P > 0, starts the timer. From the next clock on, the count reads 0, 1, …, P-1 on successive cycles and then wraps to 0.
- R4: Each wrap from P-1 to 0 gives a single-cycle `irq_o` pulse, in the same cycle in which the count reads 0. The pulses are therefore exactly P cycles apart, and with P = 1 `irq_o` stays high on every cycle.
- R5: Writing the compare register while the timer runs does not change the current period. The period is latched only when counting is enabled.
- R6: A legal write to the high mode byte with the enable bit clear stops the timer at once. The count reads 0 and no further `irq_o` pulse occurs.
- R7: Enabling while the compare register holds 0 leaves the timer stopped, with the count reading 0 and no interrupts.
- R8: A legal enabling write to the high byte while the timer is already running restarts the count from 0, with the compare value at that moment as the new period.
- R9: A write that sets any low-byte bit in mask 0x26 is rejected. The mode word is unchanged, and `err_o` is high for the one cycle after the write.
- R10: A write that sets both the enable bit (high bit 7) and the load bit (high bit 6), or any of high-byte bits 2:0, is rejected. The mode word is unchanged, the timer is unaffected, and `err_o` pulses.
- R11: A mode write of 4 bytes or more, or a 2-byte write at address 1, is rejected with an `err_o` pulse and leaves the mode word unchanged.
- R12: A legal write that reaches only the low mode byte updates that byte and does not restart or stop a running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Byte address of the register |
| bus_size | input | 2 | Transfer size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = wider |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | One-cycle pulse on each period wrap |
| err_o | output | 1 | One-cycle pulse after a rejected mode write |

## Verification
The hardest cases to reach are mode writes that arrive while the timer is part-way through a period. These include a compare change that must not shorten the current period, a low-byte write that must leave the count running, and a re-enable that must restart the count with a new period. The stimulus reaches each of them by holding the read address on the count between writes. A cycle-level model in the bench tracks the expected count, interrupt and error on every clock, so that each of these writes lands at a known phase of the period. Illegal halfword and wide writes are issued in the middle of a period, and the bench then checks that the count carries on without a break.

// File: rtl/cmpt_pkg.sv
`timescale 1ns/1ps
package cmpt_pkg;
  localparam int MODE_W = 16;
  localparam logic [7:0] LO_RSVD_MASK = 8'h26;
  localparam logic [7:0] HI_RSVD_MASK = 8'h07;
  localparam int HI_EN_BIT   = 7;
  localparam int HI_LOAD_BIT = 6;

  localparam logic [2:0] A_MODE_LO = 3'd0;
  localparam logic [2:0] A_MODE_HI = 3'd1;
  localparam logic [2:0] A_CMP     = 3'd2;
  localparam logic [2:0] A_COUNT   = 3'd4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;
endpackage

// File: rtl/cmpt_mode_regs.sv
`timescale 1ns/1ps
module cmpt_mode_regs
  import cmpt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [7:0]        mode_lo_o,
  output logic [7:0]        mode_hi_o,
  output logic              hi_wr_o,
  output logic [7:0]        hi_val_o,
  output logic              err_o
);
  xfer_size_e sz;
  logic       in_mode, size_bad, lo_touch, hi_touch, lo_bad, hi_bad, illegal;
  logic       lo_wr, hi_wr;
  logic [7:0] lo_val, hi_val;
  logic [7:0] lo_q, lo_d, hi_q, hi_d;
  logic       err_q, err_d;

  always_comb begin
    sz       = xfer_size_e'(bus_size);
    in_mode  = bus_we && (bus_addr == A_MODE_LO || bus_addr == A_MODE_HI);
    size_bad = (sz == SZ_WORD) || (sz == SZ_WIDE) ||
               ((sz == SZ_HALF) && (bus_addr == A_MODE_HI));
    lo_touch = (bus_addr == A_MODE_LO);
    hi_touch = (bus_addr == A_MODE_HI) || (sz == SZ_HALF);
    lo_val   = bus_wdata[7:0];
    hi_val   = (sz == SZ_HALF) ? bus_wdata[15:8] : bus_wdata[7:0];
    lo_bad   = (lo_val & LO_RSVD_MASK) != 8'h00;
    hi_bad   = (hi_val[HI_EN_BIT] && hi_val[HI_LOAD_BIT]) ||
               ((hi_val & HI_RSVD_MASK) != 8'h00);
    illegal  = in_mode && (size_bad || (lo_touch && lo_bad) || (hi_touch && hi_bad));
    lo_wr    = in_mode && !illegal && lo_touch;
    hi_wr    = in_mode && !illegal && hi_touch;
  end

  always_comb begin
    lo_d  = lo_wr ? lo_val : lo_q;
    hi_d  = hi_wr ? hi_val : hi_q;
    err_d = illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (lo_wr) lo_q <= lo_d;
      if (hi_wr) hi_q <= hi_d;
      err_q <= err_d;
    end
  end

  assign mode_lo_o = lo_q;
  assign mode_hi_o = hi_q;
  assign hi_wr_o   = hi_wr;
  assign hi_val_o  = hi_val;
  assign err_o     = err_q;

  // R9 R10 R11: the error pulse follows only rejected writes, and rejected writes leave the mode word as it was
  assert_err_only_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> !err_q);
  assert_reject_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(lo_q));
  assert_reject_keeps_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(hi_q));
  assert_no_en_and_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q[HI_EN_BIT] && hi_q[HI_LOAD_BIT]));
endmodule

// File: rtl/cmpt_count_core.sv
`timescale 1ns/1ps
module cmpt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             en_new,
  input  logic             mode_en,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             run_q, run_d;
  logic [CNT_W-1:0] per_q, per_d, cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             wrap, cnt_en;

  always_comb begin
    wrap   = run_q && (cnt_q == per_q - ONE);
    cnt_en = start_wr || run_q;
    run_d  = run_q;
    per_d  = per_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    if (start_wr) begin
      cnt_d = '0;
      if (en_new && (cmp_i != '0)) begin
        run_d = 1'b1;
        per_d = cmp_i;
      end else begin
        run_d = 1'b0;
      end
    end else if (run_q) begin
      if (wrap) begin
        irq_d = 1'b1;
        cnt_d = '0;
        run_d = mode_en;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      per_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        run_q <= run_d;
        cnt_q <= cnt_d;
      end
      if (start_wr) per_q <= per_d;
      irq_q <= irq_d;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  assert_idle_count_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));
  assert_count_below_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  assert_irq_at_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0));
  assert_period_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(per_q));
  assert_stop_is_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !en_new) |=> (!run_q && !irq_q && cnt_q == '0));
  assert_zero_cmp_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && cmp_i == '0) |=> !run_q);
endmodule

// File: rtl/cmpt_timer.sv
`timescale 1ns/1ps
module cmpt_timer
  import cmpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [1:0]       bus_size,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             err_o
);
  logic             rst_meta, rst_sync;
  logic [7:0]       mode_lo, mode_hi, hi_val;
  logic             hi_wr;
  logic [CNT_W-1:0] cmp_q, cmp_d, count;
  logic             cmp_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    cmp_wr = bus_we && (bus_addr == A_CMP);
    cmp_d  = cmp_wr ? bus_wdata : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) cmp_q <= '0;
    else if (cmp_wr) cmp_q <= cmp_d;
  end

  cmpt_mode_regs #(.DATA_W(CNT_W)) i_mode (
    .clk       (clk),
    .rst_n     (rst_sync),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .mode_lo_o (mode_lo),
    .mode_hi_o (mode_hi),
    .hi_wr_o   (hi_wr),
    .hi_val_o  (hi_val),
    .err_o     (err_o)
  );

  cmpt_count_core #(.CNT_W(CNT_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start_wr (hi_wr),
    .en_new   (hi_val[HI_EN_BIT]),
    .mode_en  (mode_hi[HI_EN_BIT]),
    .cmp_i    (cmp_q),
    .count_o  (count),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE_LO: bus_rdata[MODE_W-1:0] = {mode_hi, mode_lo};
      A_MODE_HI: bus_rdata[7:0]        = mode_hi;
      A_CMP:     bus_rdata             = cmp_q;
      A_COUNT:   bus_rdata             = count;
      default:   bus_rdata             = '0;
    endcase
  end

  // R12: a write reaching only the low byte keeps the high byte, and so the enable
  assert_lo_write_keeps_hi_R12: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_we && bus_addr == A_MODE_LO && bus_size == 2'd0) |=> $stable(mode_hi));
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    irq_o |-> $past(mode_hi[HI_EN_BIT]));
endmodule

// File: tb/test_cmpt_timer.sv
`timescale 1ns/1ps
module test_cmpt_timer;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_we = 1'b0;
  logic [2:0]       bus_addr = 3'd4;
  logic [1:0]       bus_size = 2'd0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic             irq_o, err_o;

  int total = 0;
  int bad = 0;
  bit chk_on = 0;
  bit done = 0;

  cmpt_timer #(.CNT_W(CNT_W)) i_cmpt_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .err_o(err_o)
  );

  always #2 clk = ~clk;

  // behavioural reference model, updated on every rising edge
  int m_lo, m_hi, m_cmp, m_per, m_cnt;
  bit m_run, m_irq, m_err;
  int  v_lo, v_hi;
  bit  v_mode, v_bad, v_lot, v_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_cmp = 0; m_per = 0; m_cnt = 0;
      m_run = 0; m_irq = 0; m_err = 0;
    end else begin
      m_irq = 0;
      v_mode = bus_we && (bus_addr == 0 || bus_addr == 1);
      v_lot  = (bus_addr == 0);
      v_hit  = (bus_addr == 1) || (bus_size == 1);
      v_lo   = bus_wdata & 'hff;
      v_hi   = (bus_size == 1) ? (bus_wdata >> 8) & 'hff : bus_wdata & 'hff;
      v_bad  = (bus_size >= 2) || (bus_size == 1 && bus_addr == 1) ||
               (v_lot && (v_lo & 'h26) != 0) ||
               (v_hit && (((v_hi & 'hc0) == 'hc0) || (v_hi & 7) != 0));
      m_err  = v_mode && v_bad;
      if (v_mode && !v_bad && v_hit) begin
        m_hi = v_hi;
        m_cnt = 0;
        if ((v_hi & 'h80) != 0 && m_cmp != 0) begin m_run = 1; m_per = m_cmp; end
        else m_run = 0;
      end else if (m_run) begin
        if (m_cnt == m_per - 1) begin
          m_irq = 1; m_cnt = 0;
          if ((m_hi & 'h80) == 0) m_run = 0;
        end else m_cnt = m_cnt + 1;
      end
      if (v_mode && !v_bad && v_lot) m_lo = v_lo;
      if (bus_we && bus_addr == 2) m_cmp = bus_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R4 irq", irq_o, m_irq);
      chk("R9 R10 R11 err", err_o, m_err);
      if (!bus_we && bus_addr == 3'd4) chk("R2 R3 count", bus_rdata, m_cnt);
    end
  end

  int last_err;
  task automatic wr(input logic [2:0] a, input logic [1:0] s, input int d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d[CNT_W-1:0];
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 3'd4; bus_size = 2'd0; bus_wdata = '0;
    @(negedge clk);
    last_err = err_o;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #1;
    bus_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  int v;
  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(5);
    chk_on = 1;
    // R1 reset state
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd4, v); chk("R1 count", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 err", err_o, 0);
    // R2 compare load alone does not start
    wr(3'd2, 2'd1, 5);
    idle(8);
    rd(3'd4, v); chk("R2 stopped count", v, 0);
    // R3 R4 enable with period 5
    wr(3'd1, 2'd0, 'h80);
    chk("R3 count after start", bus_rdata, 0);
    idle(22);
    // R5 compare change mid-period
    wr(3'd2, 2'd1, 3);
    idle(17);
    // R12 low byte only
    wr(3'd0, 2'd0, 'h01);
    chk("R12 no error", last_err, 0);
    idle(13);
    rd(3'd0, v); chk("R12 mode word", v, 'h8001);
    // R8 re-enable restarts with period 3
    wr(3'd1, 2'd0, 'h80);
    chk("R8 restart count", bus_rdata, 0);
    idle(10);
    // R9 low reserved bits
    wr(3'd0, 2'd0, 'h04);
    chk("R9 err", last_err, 1);
    rd(3'd0, v); chk("R9 mode kept", v, 'h8001);
    wr(3'd0, 2'd0, 'h20);
    chk("R9 err bit5", last_err, 1);
    // R10 enable with load, reserved high bits
    wr(3'd1, 2'd0, 'hc0);
    chk("R10 err en+load", last_err, 1);
    wr(3'd1, 2'd0, 'h81);
    chk("R10 err rsvd", last_err, 1);
    rd(3'd0, v); chk("R10 mode kept", v, 'h8001);
    idle(7);
    // R11 size rules
    wr(3'd0, 2'd2, 'h8000);
    chk("R11 err wide", last_err, 1);
    wr(3'd1, 2'd1, 'h0080);
    chk("R11 err half at hi", last_err, 1);
    rd(3'd0, v); chk("R11 mode kept", v, 'h8001);
    wr(3'd0, 2'd1, 'h8000);
    chk("R11 legal half", last_err, 0);
    rd(3'd0, v); chk("R11 half written", v, 'h8000);
    idle(9);
    // R6 stop
    wr(3'd1, 2'd0, 'h00);
    chk("R6 count zero", bus_rdata, 0);
    idle(10);
    chk("R6 no irq", irq_o, 0);
    // R7 enable with zero compare
    wr(3'd2, 2'd1, 0);
    wr(3'd1, 2'd0, 'h80);
    idle(10);
    rd(3'd4, v); chk("R7 still stopped", v, 0);
    chk("R7 no irq", irq_o, 0);
    // R4 period of one
    wr(3'd2, 2'd1, 1);
    wr(3'd1, 2'd0, 'h80);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 period one irq", irq_o, 1);
    end
    wr(3'd1, 2'd0, 'h40);
    idle(6);
    chk("R6 load-only stops", irq_o, 0);
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule